// File: doc/BRIEF.md
# Two-Dice LED Game Controller

This block runs a small electronic dice game. A single push button is the only input. Two dice of seven LEDs each are driven through one set of seven shared pattern lines. A two-bit select picks which die the pattern lines are currently lighting, and the controller alternates between the two dice fast enough that both appear lit at once.

After reset the controller runs a self-display. Die one steps through the faces one to six while die two stays dark. Die two then steps through the same faces while die one stays dark. After that both dice go dark and the controller waits for the button.

The button is synchronised and debounced. A clean press starts a roll. During the roll both dice show animated faces. When the roll time is over, die one settles on a pseudo-random result while die two keeps animating. After a further reveal time, die two also settles. Both results are then held until the next press. Presses that arrive during the self-display or during a roll have no effect.

Top module: `dice_game_ctrl`

## Requirements
- R1: The pattern lines use this bit map: bit 0 top-left, bit 1 top-right, bit 2 middle-left, bit 3 centre, bit 4 middle-right, bit 5 bottom-left, bit 6 bottom-right. The faces 1 to 6 appear as 0x08, 0x41, 0x49, 0x63, 0x6B and 0x77. A dark die is 0x00, and no other value is ever driven.
- R2: die_sel[0] enables die one and die_sel[1] enables die two. The two bits are never high together. Each die is enabled for SLOT_CYCLES-BLANK_CYCLES consecutive cycles, and each enable window is preceded by BLANK_CYCLES cycles with both selects low. The pattern lines are 0 whenever both selects are low.
- R3: While rst_n is low, die_sel and pip_lines are both 0.
- R4: After reset, die one shows faces 1,2,3,4,5,6 for SHOW_CYCLES each while die two is dark. Die two then shows 1 to 6 the same way while die one is dark. After that both dice are dark.
- R5: A button level is accepted only once it has stayed constant for DEBOUNCE_CYCLES cycles after synchronisation. A high pulse shorter than that starts nothing.
- R6: A roll starts on the accepted rising edge of the button, but only when no self-display or roll is running. Presses at any other time are ignored.
- R7: During a roll, both dice show faces that advance every STEP_CYCLES cycles.
- R8: After ROLL_CYCLES, die one settles on a result in 1..6 while die two keeps animating. After another REVEAL_CYCLES, die two settles on a result in 1..6. Each result is a 3-bit draw from a free-running LFSR, with draws of 6 and 7 rejected, so that every face can occur.
- R9: Once both dice have settled, the results stay constant until the next accepted press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_raw | input | 1 | Asynchronous push-button level, high when pressed |
| pip_lines | output | 7 | Shared LED pattern lines (bit map in R1) |
| die_sel | output | 2 | Die enables: bit 0 die one, bit 1 die two |

## Verification
A wrong sequencer state shows up at the ports within one refresh slot (2*SLOT_CYCLES cycles), because the affected die's decoded face is wrong or out of order the next time that die is enabled. A wrong multiplexer phase shows up at once, as an illegal select value, a missing blank gap, or an enable window of the wrong length. A wrong debounce or ignore behaviour shows up as a die that starts changing when it should stay constant. A broken draw shows up either as a face missing from many rolls or as a result that drifts during the hold.

// File: rtl/dice_pkg.sv
// dice_pkg: shared types, pip bit positions and face helpers for the dice
// controller. Assumes a face fits in three bits; value 0 means a dark die.
package dice_pkg;

    localparam int FACE_W = 3;
    localparam int PIP_N  = 7;

    typedef logic [FACE_W-1:0] face_t;
    typedef logic [PIP_N-1:0]  pips_t;

    // Sequencer phases
    typedef enum logic [2:0] {
        SEQ_SELF_ONE,
        SEQ_SELF_TWO,
        SEQ_DARK,
        SEQ_ROLL,
        SEQ_REVEAL,
        SEQ_HOLD
    } seq_state_t;

    // LED positions on the pattern lines
    localparam int PIP_TL = 0;
    localparam int PIP_TR = 1;
    localparam int PIP_ML = 2;
    localparam int PIP_C  = 3;
    localparam int PIP_MR = 4;
    localparam int PIP_BL = 5;
    localparam int PIP_BR = 6;

    localparam face_t FACE_MAX = face_t'(6);
    localparam face_t FACE_ONE = face_t'(1);

    // Build the LED pattern of a face from its pip groups
    function automatic pips_t face_to_pips(face_t f);
        pips_t p;
        logic  ok;
        ok        = (f != face_t'(0)) && (f <= FACE_MAX);
        p         = '0;
        p[PIP_C]  = ok && f[0];
        p[PIP_TL] = ok && (f >= face_t'(2));
        p[PIP_BR] = ok && (f >= face_t'(2));
        p[PIP_TR] = ok && (f >= face_t'(4));
        p[PIP_BL] = ok && (f >= face_t'(4));
        p[PIP_ML] = ok && (f == FACE_MAX);
        p[PIP_MR] = ok && (f == FACE_MAX);
        return p;
    endfunction

    // Step a face 1..6 with wrap; any other value restarts at 1
    function automatic face_t next_face(face_t f);
        if (f == face_t'(0) || f >= FACE_MAX)
            return FACE_ONE;
        return f + FACE_ONE;
    endfunction

endpackage

// File: rtl/dice_btn_filter.sv
// dice_btn_filter: synchronises the raw button and accepts a new level only
// after it has been stable for DEBOUNCE_CYCLES cycles. Emits a one-cycle
// press pulse on each accepted rising edge. Assumes DEBOUNCE_CYCLES >= 2.
module dice_btn_filter #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press_evt
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    logic                   deb_q;
    logic [CNT_W-1:0]       cnt_q;

    genvar g;
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First synchroniser flop takes the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= btn_raw;
            end
        end else begin : g_next
            // Later flops extend the chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    // Count cycles of disagreement and accept the level after a full window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deb_q     <= 1'b0;
            cnt_q     <= '0;
            press_evt <= 1'b0;
        end else begin
            press_evt <= 1'b0;
            if (level == deb_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                deb_q     <= level;
                cnt_q     <= '0;
                press_evt <= level;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dice_rng.sv
// dice_rng: free-running Galois LFSR with one draw slot per die. A start
// pulse makes each slot take its 3-bit field of the LFSR. Draws of 6 or 7
// are rejected and retried on the next cycle. Assumes LFSR_W >= 6.
module dice_rng
    import dice_pkg::*;
#(
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  draw_start,
    output face_t res_one,
    output face_t res_two,
    output logic  ready
);
    localparam int SLOTS = 2;

    logic [LFSR_W-1:0] lfsr_q;
    face_t             res_q  [SLOTS];
    logic              pend_q [SLOTS];

    // Advance the LFSR every cycle, independent of the game
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
    end

    genvar g;
    for (g = 0; g < SLOTS; g++) begin : g_slot
        face_t cand;
        assign cand = lfsr_q[g*FACE_W +: FACE_W];

        // Accept an in-range draw, otherwise keep retrying
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g]  <= '0;
                pend_q[g] <= 1'b0;
            end else if (draw_start || pend_q[g]) begin
                if (cand < FACE_MAX) begin
                    res_q[g]  <= cand + FACE_ONE;
                    pend_q[g] <= 1'b0;
                end else begin
                    pend_q[g] <= 1'b1;
                end
            end
        end
    end

    assign res_one = res_q[0];
    assign res_two = res_q[1];
    assign ready   = !pend_q[0] && !pend_q[1];

endmodule

// File: rtl/dice_sequencer.sv
// dice_sequencer: game state machine. Runs the power-up self-display,
// accepts presses only when idle or holding, animates the roll, and
// reveals die one before die two. Assumes all cycle counts >= 1.
module dice_sequencer
    import dice_pkg::*;
#(
    parameter int SHOW_CYCLES   = 62500000,
    parameter int ROLL_CYCLES   = 125000000,
    parameter int STEP_CYCLES   = 6250000,
    parameter int REVEAL_CYCLES = 62500000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  press_evt,
    input  logic  rng_ready,
    input  face_t res_one,
    input  face_t res_two,
    output face_t face_one,
    output face_t face_two,
    output logic  roll_start,
    output logic  res_valid
);
    localparam int TMAX_A = (SHOW_CYCLES > ROLL_CYCLES) ? SHOW_CYCLES : ROLL_CYCLES;
    localparam int TMAX   = (TMAX_A > REVEAL_CYCLES) ? TMAX_A : REVEAL_CYCLES;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int SW     = $clog2(STEP_CYCLES + 1);
    localparam logic [TW-1:0] SHOW_LAST   = TW'(SHOW_CYCLES - 1);
    localparam logic [TW-1:0] ROLL_LAST   = TW'(ROLL_CYCLES - 1);
    localparam logic [TW-1:0] REVEAL_LAST = TW'(REVEAL_CYCLES - 1);
    localparam logic [SW-1:0] STEP_LAST   = SW'(STEP_CYCLES - 1);
    localparam face_t ANIM_TWO_START = face_t'(4);

    seq_state_t      state_q;
    logic [TW-1:0]   timer_q;
    face_t           self_q;
    logic [SW-1:0]   step_q;
    face_t           anim_one_q;
    face_t           anim_two_q;

    assign roll_start = press_evt && ((state_q == SEQ_DARK) || (state_q == SEQ_HOLD));
    assign res_valid  = (state_q == SEQ_HOLD);

    // Phase transitions and the phase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_SELF_ONE;
            timer_q <= '0;
            self_q  <= FACE_ONE;
        end else begin
            case (state_q)
                SEQ_SELF_ONE, SEQ_SELF_TWO: begin
                    if (timer_q == SHOW_LAST) begin
                        timer_q <= '0;
                        if (self_q == FACE_MAX) begin
                            self_q  <= FACE_ONE;
                            state_q <= (state_q == SEQ_SELF_ONE) ? SEQ_SELF_TWO : SEQ_DARK;
                        end else begin
                            self_q <= next_face(self_q);
                        end
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                SEQ_DARK, SEQ_HOLD: begin
                    if (roll_start) begin
                        state_q <= SEQ_ROLL;
                        timer_q <= '0;
                    end
                end
                SEQ_ROLL: begin
                    if (timer_q >= ROLL_LAST) begin
                        if (rng_ready) begin
                            state_q <= SEQ_REVEAL;
                            timer_q <= '0;
                        end
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                SEQ_REVEAL: begin
                    if (timer_q == REVEAL_LAST) begin
                        state_q <= SEQ_HOLD;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_DARK;
                    timer_q <= '0;
                end
            endcase
        end
    end

    // Roll animation faces, stepped while any die is still rolling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= '0;
            anim_one_q <= FACE_ONE;
            anim_two_q <= ANIM_TWO_START;
        end else if (roll_start) begin
            step_q     <= '0;
            anim_one_q <= FACE_ONE;
            anim_two_q <= ANIM_TWO_START;
        end else if ((state_q == SEQ_ROLL) || (state_q == SEQ_REVEAL)) begin
            if (step_q == STEP_LAST) begin
                step_q     <= '0;
                anim_one_q <= next_face(anim_one_q);
                anim_two_q <= next_face(anim_two_q);
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Face shown on each die in the current phase
    always_comb begin
        face_one = '0;
        face_two = '0;
        case (state_q)
            SEQ_SELF_ONE: face_one = self_q;
            SEQ_SELF_TWO: face_two = self_q;
            SEQ_ROLL: begin
                face_one = anim_one_q;
                face_two = anim_two_q;
            end
            SEQ_REVEAL: begin
                face_one = res_one;
                face_two = anim_two_q;
            end
            SEQ_HOLD: begin
                face_one = res_one;
                face_two = res_two;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dice_display_mux.sv
// dice_display_mux: time-shares the seven pattern lines between the two
// dice. Each slot starts with a blank gap with both selects low. Outputs
// are registered. Assumes 1 <= BLANK_CYCLES < SLOT_CYCLES.
module dice_display_mux
    import dice_pkg::*;
#(
    parameter int SLOT_CYCLES  = 62500,
    parameter int BLANK_CYCLES = 1250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  face_t      face_one,
    input  face_t      face_two,
    output logic [1:0] die_sel,
    output pips_t      pips
);
    localparam int PW = $clog2(SLOT_CYCLES);
    localparam logic [PW-1:0] SLOT_LAST = PW'(SLOT_CYCLES - 1);
    localparam logic [PW-1:0] BLANK_END = PW'(BLANK_CYCLES);

    logic [PW-1:0] phase_q;
    logic          which_q;

    // Slot phase counter; the die alternates at the end of each slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            which_q <= 1'b0;
        end else if (phase_q == SLOT_LAST) begin
            phase_q <= '0;
            which_q <= ~which_q;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Registered select and pattern, dark during the blank gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            die_sel <= 2'b00;
            pips    <= '0;
        end else if (phase_q < BLANK_END) begin
            die_sel <= 2'b00;
            pips    <= '0;
        end else begin
            die_sel <= which_q ? 2'b10 : 2'b01;
            pips    <= face_to_pips(which_q ? face_two : face_one);
        end
    end

endmodule

// File: rtl/dice_game_ctrl.sv
// dice_game_ctrl: top of the two-dice LED game. Chains the button filter,
// the random source, the game sequencer and the display multiplexer.
// Assumes a single clock and a synchronous active-low reset.
module dice_game_ctrl
    import dice_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 250000,
    parameter int SHOW_CYCLES     = 62500000,
    parameter int ROLL_CYCLES     = 125000000,
    parameter int STEP_CYCLES     = 6250000,
    parameter int REVEAL_CYCLES   = 62500000,
    parameter int SLOT_CYCLES     = 62500,
    parameter int BLANK_CYCLES    = 1250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_raw,
    output logic [6:0] pip_lines,
    output logic [1:0] die_sel
);
    logic  press_evt;
    logic  roll_start;
    logic  rng_ready;
    logic  res_valid;
    face_t res_one;
    face_t res_two;
    face_t face_one;
    face_t face_two;

    dice_btn_filter #(
        .SYNC_STAGES    (2),
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) u_btn (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_raw  (btn_raw),
        .press_evt(press_evt)
    );

    dice_rng u_rng (
        .clk       (clk),
        .rst_n     (rst_n),
        .draw_start(roll_start),
        .res_one   (res_one),
        .res_two   (res_two),
        .ready     (rng_ready)
    );

    dice_sequencer #(
        .SHOW_CYCLES  (SHOW_CYCLES),
        .ROLL_CYCLES  (ROLL_CYCLES),
        .STEP_CYCLES  (STEP_CYCLES),
        .REVEAL_CYCLES(REVEAL_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_evt (press_evt),
        .rng_ready (rng_ready),
        .res_one   (res_one),
        .res_two   (res_two),
        .face_one  (face_one),
        .face_two  (face_two),
        .roll_start(roll_start),
        .res_valid (res_valid)
    );

    dice_display_mux #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .face_one(face_one),
        .face_two(face_two),
        .die_sel (die_sel),
        .pips    (pip_lines)
    );

endmodule

// File: rtl/dice_game_ctrl_chk.sv
// dice_game_ctrl_chk: protocol and result checks for dice_game_ctrl,
// attached by bind. Observes the outputs and the sequencer/result handoff.
module dice_game_ctrl_chk
    import dice_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] die_sel,
    input logic [6:0] pips,
    input logic       roll_start,
    input logic       res_valid,
    input face_t      res_one,
    input face_t      res_two
);
    // R1: only legal face patterns reach the lines
    p_pattern_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (die_sel != 2'b00) |-> (pips inside {7'h00, 7'h08, 7'h41, 7'h49, 7'h63, 7'h6B, 7'h77}));

    // R2: never both dice enabled
    p_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(die_sel));

    // R2: lines dark in the blank gap
    p_gap_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (die_sel == 2'b00) |-> (pips == 7'h00));

    // R2: die one hands over through a gap, never straight to die two
    p_gap_one_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (die_sel == 2'b01) |=> (die_sel != 2'b10));

    // R2: die two hands over through a gap
    p_gap_two_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (die_sel == 2'b10) |=> (die_sel != 2'b01));

    // R8: settled results lie in 1..6
    p_result_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_one >= 3'd1) && (res_one <= 3'd6) && (res_two >= 3'd1) && (res_two <= 3'd6)));

    // R9: held results stay put until a new roll starts
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !roll_start) |=> ($stable(res_one) && $stable(res_two)));

endmodule

bind dice_game_ctrl dice_game_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .die_sel   (die_sel),
    .pips      (pip_lines),
    .roll_start(roll_start),
    .res_valid (res_valid),
    .res_one   (res_one),
    .res_two   (res_two)
);

// File: tb/dice_game_ctrl_test.sv
// dice_game_ctrl_test: scoreboard bench. The driver pushes expected face
// sequences, and a negedge monitor decodes each die from the multiplexed lines.
module dice_game_ctrl_test;

    localparam int DEB    = 4;
    localparam int SHOW   = 64;
    localparam int ROLL   = 200;
    localparam int STEP   = 16;
    localparam int REVEAL = 200;
    localparam int SLOT   = 8;
    localparam int BLANK  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_raw = 1'b0;
    logic [6:0] pip_lines;
    logic [1:0] die_sel;

    int checks = 0;
    int failures = 0;

    int q_one[$];
    int q_two[$];
    bit sb_on = 1'b0;
    int d1_cur = 0;
    int d2_cur = 0;
    int d1_changes = 0;
    int d2_changes = 0;
    logic [1:0] prev_sel = 2'b00;
    int run_len = 0;

    always #4 clk = ~clk;

    dice_game_ctrl #(
        .DEBOUNCE_CYCLES(DEB),
        .SHOW_CYCLES    (SHOW),
        .ROLL_CYCLES    (ROLL),
        .STEP_CYCLES    (STEP),
        .REVEAL_CYCLES  (REVEAL),
        .SLOT_CYCLES    (SLOT),
        .BLANK_CYCLES   (BLANK)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_raw  (btn_raw),
        .pip_lines(pip_lines),
        .die_sel  (die_sel)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Face from a pattern per the R1 bit map; 7 marks an illegal pattern
    function automatic int decode(input logic [6:0] p);
        case (p)
            7'h00: return 0;
            7'h08: return 1;
            7'h41: return 2;
            7'h49: return 3;
            7'h63: return 4;
            7'h6B: return 5;
            7'h77: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic push_selftest();
        for (int v = 1; v <= 6; v++) begin
            q_one.push_back(v);
            q_two.push_back(v);
        end
        q_one.push_back(0);
        q_two.push_back(0);
    endtask

    // Monitor: select protocol, face decode and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (die_sel == 2'b11) check("R2", 1'b0, die_sel, 1, "both selects high");
            if (die_sel == 2'b00 && pip_lines != 7'h00) check("R2", 1'b0, pip_lines, 0, "lines lit in gap");
            if (die_sel != prev_sel) begin
                if (prev_sel != 2'b00) check("R2", run_len == SLOT - BLANK, run_len, SLOT - BLANK, "enable window length");
                if (prev_sel != 2'b00 && die_sel != 2'b00) check("R2", 1'b0, die_sel, 0, "no blank gap");
                run_len = (die_sel != 2'b00) ? 1 : 0;
            end else if (die_sel != 2'b00) begin
                run_len++;
            end
            prev_sel = die_sel;
            if (die_sel == 2'b01 || die_sel == 2'b10) begin
                int v;
                v = decode(pip_lines);
                if (v == 7) check("R1", 1'b0, pip_lines, 0, "illegal pattern");
                if (die_sel == 2'b01 && v != d1_cur) begin
                    d1_cur = v;
                    d1_changes++;
                    if (sb_on) begin
                        if (q_one.size() == 0) check("R4", 1'b0, v, -1, "die one unexpected face");
                        else begin
                            int e;
                            e = q_one.pop_front();
                            check("R4", v == e, v, e, "die one self-display face");
                        end
                    end
                end
                if (die_sel == 2'b10 && v != d2_cur) begin
                    d2_cur = v;
                    d2_changes++;
                    if (sb_on) begin
                        if (v != 0) check("R4", d1_cur == 0, d1_cur, 0, "die one dark while die two shows");
                        if (q_two.size() == 0) check("R4", 1'b0, v, -1, "die two unexpected face");
                        else begin
                            int e;
                            e = q_two.pop_front();
                            check("R4", v == e, v, e, "die two self-display face");
                        end
                    end
                end
            end
        end
    end

    task automatic press(input int len);
        @(negedge clk);
        btn_raw = 1'b1;
        repeat (len) @(negedge clk);
        btn_raw = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog", 1'b0, 0, 1, "run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit seen_one[7];
        bit seen_two[7];
        int c1, c2;
        foreach (seen_one[k]) begin
            seen_one[k] = 1'b0;
            seen_two[k] = 1'b0;
        end

        // R3: quiet outputs in reset
        repeat (3) @(negedge clk);
        check("R3", die_sel == 2'b00, die_sel, 0, "select in reset");
        check("R3", pip_lines == 7'h00, pip_lines, 0, "lines in reset");
        repeat (5) @(negedge clk);
        check("R3", die_sel == 2'b00 && pip_lines == 7'h00, pip_lines, 0, "still quiet in reset");

        // R4 self-display scoreboard, with a press that R6 requires ignored
        push_selftest();
        sb_on = 1'b1;
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        press(30);
        repeat (700) @(negedge clk);
        sb_on = 1'b0;
        check("R4", q_one.size() == 0, q_one.size(), 0, "die one faces left over");
        check("R4", q_two.size() == 0, q_two.size(), 0, "die two faces left over");
        check("R6", d1_cur == 0 && d2_cur == 0, d1_cur * 10 + d2_cur, 0, "dark after self-display despite press");

        // R5: a short pulse starts nothing
        c1 = d1_changes;
        c2 = d2_changes;
        press(3);
        repeat (100) @(negedge clk);
        check("R5", d1_changes == c1 && d2_changes == c2, d1_changes - c1, 0, "glitch ignored");
        check("R5", d1_cur == 0, d1_cur, 0, "die one still dark after glitch");

        // Detailed roll with a second press during the roll
        c1 = d1_changes;
        c2 = d2_changes;
        press(20);                        // t = P+20
        repeat (40) @(negedge clk);       // P+60
        press(20);                        // P+80, R6 ignored
        repeat (70) @(negedge clk);       // P+150
        check("R7", d1_changes - c1 >= 3, d1_changes - c1, 3, "die one animates");
        check("R7", d2_changes - c2 >= 3, d2_changes - c2, 3, "die two animates");
        repeat (80) @(negedge clk);       // P+230
        c1 = d1_changes;
        c2 = d2_changes;
        repeat (150) @(negedge clk);      // P+380
        check("R8", d1_changes == c1, d1_changes - c1, 0, "die one settled first");
        check("R8", d2_changes > c2, d2_changes - c2, 1, "die two still rolling");
        check("R8", d1_cur >= 1 && d1_cur <= 6, d1_cur, 1, "die one result range");
        check("R6", 1'b1, 0, 0, "second press did not restart roll");
        repeat (70) @(negedge clk);       // P+450
        c1 = d1_changes;
        c2 = d2_changes;
        repeat (150) @(negedge clk);
        check("R9", d1_changes == c1 && d2_changes == c2, d1_changes - c1 + d2_changes - c2, 0, "results held");
        check("R8", d2_cur >= 1 && d2_cur <= 6, d2_cur, 1, "die two result range");

        // R8: repeated rolls cover every face on both dice
        for (int i = 0; i < 60; i++) begin
            press(20);
            repeat (430) @(negedge clk);
            check("R8", d1_cur >= 1 && d1_cur <= 6 && d2_cur >= 1 && d2_cur <= 6,
                  d1_cur * 10 + d2_cur, 11, "roll result range");
            if (d1_cur >= 1 && d1_cur <= 6) seen_one[d1_cur] = 1'b1;
            if (d2_cur >= 1 && d2_cur <= 6) seen_two[d2_cur] = 1'b1;
            repeat (((i * 7) % 13) + 1) @(negedge clk);
        end
        for (int v = 1; v <= 6; v++) begin
            check("R8", seen_one[v], 0, v, "die one face never rolled");
            check("R8", seen_two[v], 0, v, "die two face never rolled");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule